// File: doc/BRIEF.md
# Consecutive Over-Current Fault Counter

This block decides when repeated over-current on a half-bridge has become a real fault. Once per low-side switching cycle it looks at whether the current-sense comparator flag was high while the low-side drive was on. Each cycle that had such an event moves a saturating count up by one. Each cycle that had none moves the count down by one. A short burst of events therefore decays away, and only a long run of faulty cycles brings the count to its limit. When the count reaches the limit, a fault request goes high and stays high.

The mode controller owns the count-enable input. It holds the enable low in modes where over-current must not count, such as ignition, and it also holds it low when it leaves the fault state. While the enable is low, the count is forced to zero, the per-cycle capture is cleared and the fault request drops. All pins are plain level signals that are synchronous to the clock. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `oc_fault_counter`

## Requirements
- R1: During reset and right after it, `count` is 0 and `fault_req` is 0.
- R2: A high `cs_flag` is ignored in any clock where `lo_drv` is sampled low. Pulses that fall only in the low-side off-time leave `count` at 0.
- R3: A cycle ends on the first clock edge that samples `lo_drv` low after an edge that sampled it high. `count` changes only on that edge. It moves by at most one, and the new value is visible right after that edge.
- R4: If `cs_flag` and `lo_drv` were both sampled high on at least one clock of the on-time, the cycle is faulty and `count` rises by one.
- R5: A cycle with no such sample is clean and lowers `count` by one. The count stops at 0.
- R6: `count` never goes above `LIMIT` (default 65). Faulty cycles at the limit leave it at `LIMIT`.
- R7: `fault_req` rises on the same edge where `count` first reaches `LIMIT`. It stays high while the enable stays high, even as clean cycles lower `count`.
- R8: On the edge after `cnt_en` is sampled low, `count` is 0 and `fault_req` is 0. Any event captured in an unfinished cycle is discarded.
- R9: While `cnt_en` is low, cycle ends leave `count` at 0 whether the cycles were faulty or clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable from the mode controller |
| lo_drv | input | 1 | Low-side drive signal, high while the low-side switch is on |
| cs_flag | input | 1 | Current-sense comparator output, high above threshold |
| fault_req | output | 1 | Sticky fault request |
| count | output | CNT_W | Current count, 0 to LIMIT |

## Verification
The assertions assume that `lo_drv`, `cs_flag` and `cnt_en` are synchronous to `clk` and change only between edges. They also assume that the mode controller may drop `cnt_en` at any point in a switching cycle, including mid on-time. The stimulus changes every input at the falling clock edge. It builds each switching cycle from whole clocks of on-time and off-time, from one clock upward. Enable changes fall both at cycle boundaries and inside the on-time, so every case covered by the assertions' assumptions is driven.

// File: rtl/oc_fault_pkg.sv
package oc_fault_pkg;
  // Outcome of one low-side switching cycle, as seen by the counter.
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,  // no cycle boundary this clock
    EV_CLEAN = 2'd1,  // boundary, no qualified over-current during on-time
    EV_FAULT = 2'd2   // boundary, at least one qualified over-current
  } cyc_ev_e;
endpackage

// File: rtl/oc_cycle_capture.sv
module oc_cycle_capture
  import oc_fault_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cnt_en,
  input  logic    lo_drv,
  input  logic    cs_flag,
  output cyc_ev_e cyc_ev
);
  logic lo_q;
  logic hit_q;
  logic lo_fall;
  logic qualified;

  assign lo_fall   = lo_q & ~lo_drv;
  assign qualified = lo_drv & cs_flag;

  // Delayed copy of the low-side drive for edge detection. It runs even
  // while counting is disabled, so a cycle that ends right after
  // re-enable is still seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= 1'b0;
    else        lo_q <= lo_drv;
  end

  // Per-cycle over-current capture, cleared at each boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hit_q <= 1'b0;
    else if (!cnt_en)   hit_q <= 1'b0;
    else if (lo_fall)   hit_q <= 1'b0;
    else if (qualified) hit_q <= 1'b1;
  end

  always_comb begin
    cyc_ev = EV_NONE;
    if (cnt_en && lo_fall) cyc_ev = hit_q ? EV_FAULT : EV_CLEAN;
  end
endmodule

// File: rtl/oc_sat_updown.sv
module oc_sat_updown
  import oc_fault_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int LIMIT = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  cyc_ev_e          cyc_ev,
  output logic [CNT_W-1:0] count,
  output logic             reach
);
  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;
  logic             at_zero;

  assign at_top  = (cnt_q == LIM_V);
  assign at_zero = (cnt_q == '0);
  // Pulse when this faulty cycle takes the count onto the limit.
  assign reach   = (cyc_ev == EV_FAULT) && (cnt_q == LIM_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!cnt_en) cnt_q <= '0;
    else begin
      unique case (cyc_ev)
        EV_FAULT: if (!at_top)  cnt_q <= cnt_q + ONE;
        EV_CLEAN: if (!at_zero) cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic reach,
  output logic fault_req
);
  logic flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flt_q <= 1'b0;
    else if (!cnt_en) flt_q <= 1'b0;
    else if (reach)   flt_q <= 1'b1;
  end

  assign fault_req = flt_q;
endmodule

// File: rtl/oc_fault_counter.sv
module oc_fault_counter
  import oc_fault_pkg::*;
#(
  parameter int LIMIT = 65,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             lo_drv,
  input  logic             cs_flag,
  output logic             fault_req,
  output logic [CNT_W-1:0] count
);
  cyc_ev_e cyc_ev;
  logic    reach;

  oc_cycle_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .lo_drv (lo_drv),
    .cs_flag(cs_flag),
    .cyc_ev (cyc_ev)
  );

  oc_sat_updown #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_en(cnt_en),
    .cyc_ev(cyc_ev),
    .count (count),
    .reach (reach)
  );

  oc_fault_latch u_flt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .reach    (reach),
    .fault_req(fault_req)
  );
endmodule

// File: rtl/oc_fault_counter_chk.sv
module oc_fault_counter_chk #(
  parameter int LIMIT = 65,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             lo_drv,
  input logic             fault_req,
  input logic [CNT_W-1:0] count
);
  // Clocks seen since reset, saturating, so that $past never reaches
  // back before reset.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_cnt_le_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= LIMIT);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(cnt_en)) |->
      (int'(count) - int'($past(count)) <= 1 && int'($past(count)) - int'(count) <= 1));

  assert_change_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(cnt_en) && count != $past(count)) |->
      ($past(lo_drv, 2) && !$past(lo_drv)));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(cnt_en) && $past(fault_req)) |-> fault_req);

  assert_limit_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == LIMIT) |-> fault_req);

  assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (count == '0 && !fault_req));
endmodule

bind oc_fault_counter oc_fault_counter_chk #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .lo_drv   (lo_drv),
  .fault_req(fault_req),
  .count    (count)
);

// File: tb/oc_fault_counter_tb.sv
`timescale 1ns/1ps
module oc_fault_counter_tb;
  localparam int LIMIT = 65;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cnt_en = 1'b0;
  logic             lo_drv = 1'b0;
  logic             cs_flag = 1'b0;
  logic             fault_req;
  logic [CNT_W-1:0] count;

  oc_fault_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .lo_drv(lo_drv),
    .cs_flag(cs_flag), .fault_req(fault_req), .count(count)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference model, updated at every rising edge.
  int m_cnt = 0;
  bit m_fault = 0, m_hit = 0, m_lo_prev = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_fault = 0; m_hit = 0; m_lo_prev = 0;
    end else begin
      if (!cnt_en) begin
        m_cnt = 0; m_fault = 0; m_hit = 0;
      end else if (m_lo_prev && !lo_drv) begin
        if (m_hit) begin
          if (m_cnt < LIMIT) m_cnt++;
          if (m_cnt == LIMIT) m_fault = 1;
        end else if (m_cnt > 0) m_cnt--;
        m_hit = 0;
      end else if (lo_drv && cs_flag) m_hit = 1;
      m_lo_prev = lo_drv;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // One clock: compare against the model at the falling edge.
  task automatic step();
    @(negedge clk);
    chk(cur_req, "count", int'(count), m_cnt);
    chk(cur_req, "fault_req", int'(fault_req), int'(m_fault));
  endtask

  task automatic pulse(int on_len, int off_len, bit cs_on, bit cs_off);
    lo_drv = 1'b1; cs_flag = cs_on;
    repeat (on_len) step();
    lo_drv = 1'b0; cs_flag = cs_off;
    repeat (off_len) step();
    cs_flag = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", int'(count), 0);
    chk("R1", "fault in reset", int'(fault_req), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "count after reset", int'(count), 0);
    cnt_en = 1'b1;

    // R2: sense pulses only during off-time
    cur_req = "R2";
    repeat (3) pulse(3, 3, 1'b0, 1'b1);
    chk("R2", "count after off-time pulses", int'(count), 0);

    // R3: one event on the last on-clock; count moves on the falling edge
    cur_req = "R3";
    lo_drv = 1'b1; step(); step();
    cs_flag = 1'b1; step();
    lo_drv = 1'b0; cs_flag = 1'b0;
    step();
    chk("R3", "count right after boundary", int'(count), 1);
    step();

    // R4: faulty cycles step up
    cur_req = "R4";
    repeat (4) pulse(2, 2, 1'b1, 1'b0);
    chk("R4", "count after 4 faulty", int'(count), 5);

    // R5: clean cycles step down and stop at zero
    cur_req = "R5";
    repeat (8) pulse(2, 2, 1'b0, 1'b0);
    chk("R5", "count saturates at 0", int'(count), 0);

    // R7 / R6: run to the limit, saturate, then decay with sticky fault
    cur_req = "R7";
    repeat (LIMIT - 1) pulse(1, 1, 1'b1, 1'b0);
    chk("R7", "count one below limit", int'(count), LIMIT - 1);
    chk("R7", "no fault below limit", int'(fault_req), 0);
    pulse(1, 1, 1'b1, 1'b0);
    chk("R7", "fault at limit", int'(fault_req), 1);
    cur_req = "R6";
    repeat (5) pulse(2, 1, 1'b1, 1'b0);
    chk("R6", "count held at limit", int'(count), LIMIT);
    cur_req = "R7";
    repeat (10) pulse(1, 2, 1'b0, 1'b0);
    chk("R7", "count decays", int'(count), LIMIT - 10);
    chk("R7", "fault stays raised", int'(fault_req), 1);

    // R8: disable clears everything
    cur_req = "R8";
    cnt_en = 1'b0;
    step();
    chk("R8", "count cleared", int'(count), 0);
    chk("R8", "fault cleared", int'(fault_req), 0);

    // R9: boundaries while disabled do nothing
    cur_req = "R9";
    repeat (3) pulse(2, 2, 1'b1, 1'b0);
    chk("R9", "count while disabled", int'(count), 0);

    // R8: event captured, then disable mid on-time discards it
    cur_req = "R8";
    cnt_en = 1'b1;
    lo_drv = 1'b1; cs_flag = 1'b1; step();
    cnt_en = 1'b0; step();
    cnt_en = 1'b1; cs_flag = 1'b0; step();
    lo_drv = 1'b0; step(); step();
    chk("R8", "discarded capture", int'(count), 0);

    // Mixed patterns from an LFSR
    cur_req = "R4";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[7:0] == 8'h00) cnt_en = ~cnt_en;
        else if (!cnt_en && lf[2]) cnt_en = 1'b1;
        pulse(1 + int'(lf[1:0]), 1 + int'(lf[4:3]), lf[5] | lf[6], lf[8]);
      end
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule